// File: doc/BRIEF.md
# Crosspoint Switch Parallel Command Controller

This block is the digital control core of an eight-output video crosspoint switch, driven through a seven-bit parallel word. The word has a three-bit output address and a four-bit code. Codes below eight pick one of eight input channels for the addressed output. Code eight ties that output's buffer input to ground. The remaining codes act as commands: they turn one buffer or all buffers on or off, or they request a software latch.

Writes pass through a first rank of registers, one entry per output. A second rank drives the routing outputs. Several outputs can be staged one at a time and then switched together. The second rank loads in one of two ways, chosen by a mode pin. In edge mode it loads on a rising edge of the latch line. In level mode it follows the first rank while the latch line is low.

The write strobe and the latch line are asynchronous. Each passes through a two-flop synchroniser clocked by the system clock, and its rising edges are detected from the registered history. The write strobe is gated by two chip enables before it is synchronised: one active high and one active low. An accepted strobe edge acts on the third clock edge after it.

Top module: `xpt_ctrl`

## Requirements
- R1: A write takes effect only while `ce_hi` is 1 and `ce_lo_n` is 0. A strobe given under any other enable state changes neither rank nor any enable flag.
- R2: Code values 0 to 7 (code bit 3 = 0) set the addressed output's first-rank entry to input channel `cmd_data[2:0]` and clear its ground flag. The change reaches `sel_out[3*k+2:3*k]` only after a second-rank load.
- R3: A write changes the first-rank entry of the addressed output only. Several writes followed by one latch pulse move all staged outputs in the same clock cycle.
- R4: Code 8 (binary 1000) sets the addressed output's ground flag and sets its selection to 0. Both become visible after a second-rank load.
- R5: Code 11 (1011) clears the addressed output's enable flag and keeps its routing. Code 12 (1100) sets that flag again, which restores the previously routed channel.
- R6: Code 13 (1101) clears every enable flag. Code 14 (1110) sets every enable flag.
- R7: Codes 11 to 14 also copy the whole first rank into the second rank, whatever the state of the latch line.
- R8: Code 15 (1111) copies the first rank into the second rank when the latch line is high. In edge mode with the latch line low, it has no effect.
- R9: In edge mode (`edge_mode` = 1), the second rank loads on a rising edge of the latch line only. It holds while the line stays high or stays low.
- R10: In level mode (`edge_mode` = 0), the second rank follows the first rank while the latch line is low. It freezes while the line is high.
- R11: Reset clears every enable flag. It leaves the channel selections and ground flags as they were.
- R12: Codes 9 (1001) and 10 (1010) change neither rank nor any enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset, active high |
| wr_strobe | input | 1 | Asynchronous write strobe; acts on its rising edge |
| ce_hi | input | 1 | Active-high chip enable for the strobe |
| ce_lo_n | input | 1 | Active-low chip enable for the strobe |
| out_addr | input | 3 | Output address of the write |
| cmd_data | input | 4 | Channel index or command code |
| latch_line | input | 1 | Asynchronous second-rank load line |
| edge_mode | input | 1 | 1 = load on latch rising edge, 0 = transparent while latch low |
| sel_out | output | 24 | Selected input channel, 3 bits per output, output 0 in the low bits |
| gnd_out | output | 8 | Ground-select flag per output |
| en_out | output | 8 | Buffer-enable flag per output |

## Verification
Staging tests route every output without a latch, then check that nothing moves until one latch pulse moves all eight outputs together. A design that wrote the second rank directly would change the outputs one write at a time. The enable commands are applied after a route that has not yet been latched, which shows that they pull in the first rank as well; a design without that reload keeps the old channel after a restore. The software latch is issued with the latch line low and then high, and level mode is checked both transparent and frozen. A design that ignored the line state in either case would update at the wrong moment. Chip-enable gating, the two no-operation codes and a mid-run reset are checked for unchanged outputs: a mis-gated strobe, a decoded no-op or a reset that clears routing would show a changed selection.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int CODE_W = 4;
  localparam int SEL_W  = CODE_W - 1;

  typedef struct packed {
    logic             gnd;
    logic [SEL_W-1:0] sel;
  } route_t;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_ROUTE,
    OP_GROUND,
    OP_OFF_ONE,
    OP_ON_ONE,
    OP_OFF_ALL,
    OP_ON_ALL,
    OP_SOFT_LATCH
  } op_e;

  // Classify a 4-bit code word.
  function automatic op_e decode_op(input logic [CODE_W-1:0] code);
    op_e res;
    if (!code[CODE_W-1]) begin
      res = OP_ROUTE;
    end else begin
      case (code[SEL_W-1:0])
        3'd0:    res = OP_GROUND;
        3'd3:    res = OP_OFF_ONE;
        3'd4:    res = OP_ON_ONE;
        3'd5:    res = OP_OFF_ALL;
        3'd6:    res = OP_ON_ALL;
        3'd7:    res = OP_SOFT_LATCH;
        default: res = OP_NOP;
      endcase
    end
    return res;
  endfunction

  // Routing entry a route or ground code produces.
  function automatic route_t route_of(input logic [CODE_W-1:0] code);
    route_t r;
    r.gnd = code[CODE_W-1];
    r.sel = code[CODE_W-1] ? '0 : code[SEL_W-1:0];
    return r;
  endfunction

  // Commands that also refresh the second rank.
  function automatic logic reloads_rank2(input op_e op);
    return (op == OP_OFF_ONE) || (op == OP_ON_ONE) ||
           (op == OP_OFF_ALL) || (op == OP_ON_ALL);
  endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic rise
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], d};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("rise held two cycles"); // R3

endmodule

// File: rtl/xpt_rank1.sv
module xpt_rank1 import xpt_pkg::*; #(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_go,
  input  op_e                       op,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CODE_W-1:0]         wr_code,
  output route_t [N_OUT-1:0]        r1_q
);

  logic is_route_write;
  assign is_route_write = wr_go && ((op == OP_ROUTE) || (op == OP_GROUND));

  for (genvar i = 0; i < N_OUT; i++) begin : g_entry
    logic hit;
    assign hit = is_route_write && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) r1_q[i] <= route_of(wr_code);
    end
  end

  AST_R1_NOP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_go && op == OP_NOP) |=> $stable(r1_q)) else $error("nop changed rank1"); // R12

  AST_R1_CMD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_go && reloads_rank2(op)) |=> $stable(r1_q)) else $error("command changed rank1"); // R5

endmodule

// File: rtl/xpt_rank2.sv
module xpt_rank2 import xpt_pkg::*; #(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  route_t [N_OUT-1:0]        r1_d,
  input  logic                      cmd_go,
  input  op_e                       op,
  input  logic [AW-1:0]             cmd_addr,
  input  logic                      edge_mode,
  input  logic                      latch_lvl,
  input  logic                      latch_rise,
  output route_t [N_OUT-1:0]        r2_q,
  output logic [N_OUT-1:0]          en_q
);

  logic pin_load, reload_cmd, soft_load, load_now;

  assign pin_load   = edge_mode ? latch_rise : ~latch_lvl;
  assign reload_cmd = cmd_go && reloads_rank2(op);
  assign soft_load  = cmd_go && (op == OP_SOFT_LATCH) && latch_lvl;
  assign load_now   = pin_load | reload_cmd | soft_load;

  always_ff @(posedge clk) begin
    if (load_now) r2_q <= r1_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (cmd_go) begin
      case (op)
        OP_OFF_ONE: en_q[cmd_addr] <= 1'b0;
        OP_ON_ONE:  en_q[cmd_addr] <= 1'b1;
        OP_OFF_ALL: en_q <= '0;
        OP_ON_ALL:  en_q <= '1;
        default:    en_q <= en_q;
      endcase
    end
  end

  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      AST_POR_OFF: assert (en_q == '0) else $error("enable survived reset"); // R11
    end
  end

  AST_EDGE_COPY: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && latch_rise) |=> (r2_q == $past(r1_d))) else $error("edge load missed"); // R9

  AST_LEVEL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && latch_lvl && !cmd_go) |=> $stable(r2_q)) else $error("rank2 moved while frozen"); // R10

  AST_CMD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    reload_cmd |=> (r2_q == $past(r1_d))) else $error("command did not reload"); // R7

  AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && op == OP_OFF_ALL) |=> (en_q == '0)) else $error("all-off failed"); // R6

  AST_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && op == OP_ON_ALL) |=> (en_q == '1)) else $error("all-on failed"); // R6

  AST_NOP_EN: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && op == OP_NOP) |=> $stable(en_q)) else $error("nop changed enables"); // R12

endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl import xpt_pkg::*; #(
  parameter int N_OUT       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic                     clk,
  input  logic                     por,
  input  logic                     wr_strobe,
  input  logic                     ce_hi,
  input  logic                     ce_lo_n,
  input  logic [AW-1:0]            out_addr,
  input  logic [CODE_W-1:0]        cmd_data,
  input  logic                     latch_line,
  input  logic                     edge_mode,
  output logic [N_OUT*SEL_W-1:0]   sel_out,
  output logic [N_OUT-1:0]         gnd_out,
  output logic [N_OUT-1:0]         en_out
);

  logic wr_gated, wr_lvl, wr_go, latch_lvl, latch_rise;
  op_e  op;
  route_t [N_OUT-1:0] r1_q, r2_q;
  logic [N_OUT-1:0]   en_q;

  assign wr_gated = wr_strobe & ce_hi & ~ce_lo_n;
  assign op       = decode_op(cmd_data);

  xpt_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(por), .d(wr_gated), .level(wr_lvl), .rise(wr_go)
  );

  xpt_sync #(.STAGES(SYNC_STAGES)) u_latch_sync (
    .clk(clk), .rst(por), .d(latch_line), .level(latch_lvl), .rise(latch_rise)
  );

  xpt_rank1 #(.N_OUT(N_OUT)) u_rank1 (
    .clk(clk), .rst(por), .wr_go(wr_go), .op(op),
    .wr_addr(out_addr), .wr_code(cmd_data), .r1_q(r1_q)
  );

  xpt_rank2 #(.N_OUT(N_OUT)) u_rank2 (
    .clk(clk), .rst(por), .r1_d(r1_q), .cmd_go(wr_go), .op(op),
    .cmd_addr(out_addr), .edge_mode(edge_mode), .latch_lvl(latch_lvl),
    .latch_rise(latch_rise), .r2_q(r2_q), .en_q(en_q)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign sel_out[i*SEL_W +: SEL_W] = r2_q[i].sel;
    assign gnd_out[i]                = r2_q[i].gnd;
  end
  assign en_out = en_q;

  AST_WR_ISOLATE: assert property (@(posedge clk) disable iff (por)
    !wr_lvl |=> $stable(r1_q)) else $error("rank1 changed without strobe"); // R1

  AST_WR_EN_ISOLATE: assert property (@(posedge clk) disable iff (por)
    !wr_lvl |=> $stable(en_q)) else $error("enables changed without strobe"); // R1

endmodule

// File: tb/sim_xpt_ctrl.sv
module sim_xpt_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por = 1'b1, wr_strobe = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic [2:0] out_addr = '0;
  logic [3:0] cmd_data = '0;
  logic latch_line = 1'b0, edge_mode = 1'b1;
  logic [N*3-1:0] sel_out;
  logic [N-1:0] gnd_out, en_out;

  xpt_ctrl #(.N_OUT(N)) u0 (
    .clk(clk), .por(por), .wr_strobe(wr_strobe), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .out_addr(out_addr), .cmd_data(cmd_data), .latch_line(latch_line),
    .edge_mode(edge_mode), .sel_out(sel_out), .gnd_out(gnd_out), .en_out(en_out)
  );

  int checks = 0, errors = 0;

  logic [2:0] m1s [N];
  logic [2:0] m2s [N];
  logic       m1g [N];
  logic       m2g [N];
  logic [N-1:0] men;

  typedef struct packed { logic [2:0] a; logic [3:0] c; logic lat; } vec_t;
  localparam vec_t TBL [19] = '{
    '{3'd0, 4'd7, 1'b0},  // R2 R3 staged, outputs unchanged
    '{3'd1, 4'd6, 1'b0},
    '{3'd2, 4'd5, 1'b0},
    '{3'd3, 4'd4, 1'b0},
    '{3'd4, 4'd3, 1'b0},
    '{3'd5, 4'd2, 1'b0},
    '{3'd6, 4'd1, 1'b0},
    '{3'd7, 4'd0, 1'b1},  // R3 one latch moves all outputs
    '{3'd3, 4'd8, 1'b1},  // R4 ground
    '{3'd0, 4'd14, 1'b0}, // R6 all on
    '{3'd2, 4'd11, 1'b0}, // R5 off one
    '{3'd5, 4'd0, 1'b0},  // R2 staged only
    '{3'd2, 4'd12, 1'b0}, // R5 R7 on one with reload
    '{3'd0, 4'd13, 1'b0}, // R6 all off
    '{3'd4, 4'd9, 1'b0},  // R12 nop
    '{3'd6, 4'd10, 1'b0}, // R12 nop
    '{3'd1, 4'd14, 1'b0}, // R6 all on again
    '{3'd6, 4'd2, 1'b0},  // R2 staged
    '{3'd6, 4'd10, 1'b1}  // R12 nop then R9 latch
  };

  function automatic void copy12();
    for (int i = 0; i < N; i++) begin
      m2s[i] = m1s[i];
      m2g[i] = m1g[i];
    end
  endfunction

  task automatic check_all(input string tag);
    logic [N*3-1:0] es;
    logic [N-1:0] eg;
    for (int i = 0; i < N; i++) begin
      es[i*3 +: 3] = m2s[i];
      eg[i] = m2g[i];
    end
    checks++;
    if (sel_out !== es || gnd_out !== eg || en_out !== men) begin
      errors++;
      $display("FAIL %s: sel=%h gnd=%b en=%b expected sel=%h gnd=%b en=%b",
               tag, sel_out, gnd_out, en_out, es, eg, men);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [3:0] c);
    @(negedge clk);
    out_addr = a; cmd_data = c; wr_strobe = 1'b1;
    repeat (3) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    if (ce_hi && !ce_lo_n) begin
      if (c < 4'd8) begin
        m1s[a] = c[2:0]; m1g[a] = 1'b0;
      end else begin
        case (c)
          4'd8:  begin m1s[a] = 3'd0; m1g[a] = 1'b1; end
          4'd11: begin men[a] = 1'b0; copy12(); end
          4'd12: begin men[a] = 1'b1; copy12(); end
          4'd13: begin men = '0; copy12(); end
          4'd14: begin men = '1; copy12(); end
          4'd15: if (latch_line) copy12();
          default: ;
        endcase
      end
    end
    if (!edge_mode && !latch_line) copy12();
  endtask

  task automatic set_latch(input logic v);
    logic was;
    was = latch_line;
    @(negedge clk);
    latch_line = v;
    repeat (5) @(negedge clk);
    if (edge_mode && v && !was) copy12();
    if (!edge_mode && !v) copy12();
  endtask

  task automatic pulse_latch();
    set_latch(1'b1);
    set_latch(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m1s[i] = '0; m1g[i] = 1'b0; m2s[i] = '0; m2g[i] = 1'b0;
    end
    men = '0;
    repeat (4) @(negedge clk);
    por = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (en_out !== '0) begin
      errors++;
      $display("FAIL R11 reset: en=%b expected %b", en_out, 8'h00);
    end

    // Give both ranks a known content before full-output comparisons.
    for (int i = 0; i < N; i++) do_write(3'(i), 4'd0);
    pulse_latch();
    check_all("R9 initial latch");

    foreach (TBL[k]) begin
      do_write(TBL[k].a, TBL[k].c);
      if (TBL[k].lat) pulse_latch();
      check_all($sformatf("table entry %0d", k));
    end

    // R1: chip-enable gating
    ce_hi = 1'b0;
    do_write(3'd0, 4'd3);
    do_write(3'd1, 4'd13);
    pulse_latch();
    check_all("R1 ce_hi low ignored");
    ce_hi = 1'b1; ce_lo_n = 1'b1;
    do_write(3'd0, 4'd5);
    pulse_latch();
    check_all("R1 ce_lo_n high ignored");
    ce_lo_n = 1'b0;

    // R8: soft latch with line low in edge mode
    do_write(3'd1, 4'd2);
    do_write(3'd0, 4'd15);
    check_all("R8 soft latch ignored while line low");
    set_latch(1'b1);
    check_all("R9 rising edge load");
    do_write(3'd1, 4'd5);
    check_all("R9 hold while line high");
    do_write(3'd0, 4'd15);
    check_all("R8 soft latch with line high");
    set_latch(1'b0);
    check_all("R9 no load on falling edge");

    // R10: level mode
    edge_mode = 1'b0;
    repeat (4) @(negedge clk);
    copy12();
    do_write(3'd2, 4'd3);
    check_all("R10 transparent while line low");
    set_latch(1'b1);
    do_write(3'd2, 4'd4);
    do_write(3'd7, 4'd8);
    check_all("R10 frozen while line high");
    set_latch(1'b0);
    check_all("R10 update on release");

    // R11: reset mid-run keeps routing
    @(negedge clk);
    por = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0;
    repeat (4) @(negedge clk);
    men = '0;
    check_all("R11 reset clears enables only");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule